// File: doc/BRIEF.md
# Twelve-Bit Word to Byte Sector Packer

This block is the data path between a 12-bit host data register and a byte-wide sector buffer. A transfer is opened with a single start pulse. The pulse chooses the direction: fill moves data from the host into the buffer, and empty moves data from the buffer to the host. It also chooses the item format. In byte mode each handshake moves one byte. In word mode each handshake moves one 12-bit word. Two consecutive words are bit-packed across three bytes, so a full word-mode sector uses only the front three quarters of the buffer. A word-mode fill ends by zeroing the rest of the buffer.

The host waits for the transfer-ready flag. It then either writes a word with a write strobe or takes the current item with a read strobe. Each accepted strobe drops the flag while the block steps through its internal single-port RAM. The flag comes back when the next item can be moved. When the item count is reached, the block raises done instead. In byte mode the value the host reads is merged into an accumulator value that the host supplies. Command decoding and the disk medium sit outside this block.

Top module: `sector_packer`

## Requirements
- R1: While reset is applied, and after it is released, xfer_ready and done are 0 and data_out is 0 (word mode, data register cleared).
- R2: A start pulse with start_dir=0 (fill), given while idle, raises xfer_ready on the next clock and clears done.
- R3: In byte mode (start_mode8=1) a transfer moves SECTOR_BYTES items. Item k of a fill goes to buffer byte k, using host_wdata[7:0]. Item k of an empty comes from buffer byte k.
- R4: In word mode a transfer moves SECTOR_BYTES/2 words. Word n uses base byte b=(3n)>>1. For an even n, a fill writes word bits 11:4 to byte b. It writes bits 3:0 to bits 7:4 of byte b+1 and clears bits 3:0 of byte b+1.
- R5: For an odd n, a word-mode fill writes word bits 11:8 to bits 3:0 of byte b and leaves bits 7:4 of b unchanged. It writes word bits 7:0 to byte b+1.
- R6: A word-mode empty presents an even word as {byte b, byte b+1 bits 7:4} and an odd word as {byte b bits 3:0, byte b+1}.
- R7: After the last word of a word-mode fill, bytes 3·SECTOR_BYTES/4 to SECTOR_BYTES-1 read back as zero, and done rises only after all of them are cleared.
- R8: data_out is acc_in OR {4'b0, data register bits 7:0} in byte mode, and the whole 12-bit data register in word mode.
- R9: On a fill, xfer_ready drops on the clock after an accepted host_we. It rises again 3 clocks (byte mode) or 5 clocks (word mode) after the strobe edge. After the last item, done rises after 3 clocks (byte mode) or 5+SECTOR_BYTES/4 clocks (word mode) instead.
- R10: On an empty, the first item and each next item are ready 3 clocks (byte mode) or 4 clocks (word mode) after the start or read edge. A host_rd taken once all items have been delivered raises done on the next clock.
- R11: host_we and host_rd are ignored while xfer_ready is 0 or when they do not match the direction. start is ignored while a transfer is active. Mode and direction are sampled only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Opens a transfer when idle |
| start_mode8 | input | 1 | 1 = byte mode, 0 = 12-bit word mode; sampled at start |
| start_dir | input | 1 | 0 = fill buffer, 1 = empty buffer; sampled at start |
| host_we | input | 1 | Host write strobe for a fill item |
| host_wdata | input | 12 | Host write data |
| host_rd | input | 1 | Host read strobe: item taken, fetch next |
| acc_in | input | 12 | Accumulator value merged into byte-mode reads |
| data_out | output | 12 | Value presented to the host |
| xfer_ready | output | 1 | Next item may be moved |
| done | output | 1 | Transfer complete; held until the next start |

## Verification
The bench builds the block with the default SECTOR_BYTES of 128. This puts the full 64-word packing in reach, along with the 96/32 split between packed bytes and the zeroed tail. A byte-mode fill first writes a non-zero pattern over the whole buffer, so tail clearing after the word-mode fill is visible. A later byte-mode empty then reads every packed nibble boundary directly. The reference model holds the buffer as a flat bit stream. It predicts ready, done and data on every clock, including the 37-clock completion delay of a word-mode fill.

// File: rtl/sector_pack_pkg.sv
`timescale 1ns/1ps
package sector_pack_pkg;

  localparam int WORD_W = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_CLR,
    ST_FA,
    ST_FB,
    ST_FC
  } pk_state_e;

  typedef enum logic {
    DIR_FILL  = 1'b0,
    DIR_EMPTY = 1'b1
  } pk_dir_e;

endpackage

// File: rtl/sector_ram.sv
`timescale 1ns/1ps
module sector_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  // single port: a write cycle leaves the read register untouched
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[addr] <= wdata;
    end else begin
      rdata <= mem_q[addr];
    end
  end

endmodule

// File: rtl/pack_lane.sv
`timescale 1ns/1ps
module pack_lane
  import sector_pack_pkg::*;
(
  input  logic              mode8,
  input  logic              odd,
  input  logic              half,
  input  logic [WORD_W-1:0] word,
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] wr_byte,
  output logic [WORD_W-1:0] rd_word
);

  logic unused_low;
  assign unused_low = ^old_byte[NIB_W-1:0];

  // merge of one host word into the byte under access
  always_comb begin
    if (mode8) begin
      wr_byte = word[BYTE_W-1:0];
    end else begin
      case ({odd, half})
        2'b00:   wr_byte = word[WORD_W-1:NIB_W];
        2'b01:   wr_byte = {word[NIB_W-1:0], {NIB_W{1'b0}}};
        2'b10:   wr_byte = {old_byte[BYTE_W-1:NIB_W], word[WORD_W-1:BYTE_W]};
        default: wr_byte = word[BYTE_W-1:0];
      endcase
    end
  end

  // rebuild of one host word from two buffer bytes
  always_comb begin
    if (mode8) begin
      rd_word = {{NIB_W{1'b0}}, lo_byte};
    end else if (odd) begin
      rd_word = {hi_byte[NIB_W-1:0], lo_byte};
    end else begin
      rd_word = {hi_byte, lo_byte[BYTE_W-1:NIB_W]};
    end
  end

endmodule

// File: rtl/pack_ctrl.sv
`timescale 1ns/1ps
module pack_ctrl
  import sector_pack_pkg::*;
#(
  parameter int SECTOR_BYTES = 128
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              start_mode8,
  input  logic                              start_dir,
  input  logic                              host_we,
  input  logic                              host_rd,
  output logic                              xfer_ready,
  output logic                              done,
  output logic                              busy,
  output logic                              mode8,
  output logic                              dir_empty,
  output logic [$clog2(SECTOR_BYTES):0]     ptr,
  output logic                              odd,
  output logic                              half,
  output logic                              ram_we,
  output logic                              clear_sel,
  output logic                              host_ld,
  output logic                              fetch_ld,
  output logic                              tmp_ld,
  output logic [$clog2(SECTOR_BYTES)-1:0]   ram_addr
);

  localparam int ADDR_W = $clog2(SECTOR_BYTES);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int WORDS  = SECTOR_BYTES / 2;
  localparam int PACKED = (WORDS * 3) / 2;

  pk_state_e         state_q, state_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              half_q, half_d;
  logic              mode8_q, dir_q;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] clr_q, clr_d;
  logic              cfg_en;

  logic [PTR_W-1:0]  item_count;
  logic [PTR_W-1:0]  ptr_inc;
  logic              last_item;
  logic [PTR_W+1:0]  triple;
  logic [ADDR_W-1:0] word_base;
  logic              hi_sel;
  logic              unused_bits;

  assign item_count = mode8_q ? PTR_W'(SECTOR_BYTES) : PTR_W'(WORDS);
  assign ptr_inc    = ptr_q + 1'b1;
  assign last_item  = (ptr_inc == item_count);
  assign triple     = {2'b00, ptr_q} + {1'b0, ptr_q, 1'b0};
  assign word_base  = triple[ADDR_W:1];
  assign unused_bits = ^{triple[PTR_W+1:ADDR_W+1], triple[0]};
  assign hi_sel     = half_q | (state_q == ST_FB);
  assign cfg_en     = (state_q == ST_IDLE) && start;

  // next-state process
  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    half_d    = half_q;
    done_d    = done_q;
    clr_d     = clr_q;
    ram_we    = 1'b0;
    clear_sel = 1'b0;
    host_ld   = 1'b0;
    fetch_ld  = 1'b0;
    tmp_ld    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          ptr_d   = '0;
          half_d  = 1'b0;
          done_d  = 1'b0;
          state_d = (start_dir == DIR_EMPTY) ? ST_FA : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if ((dir_q == DIR_FILL) && host_we) begin
          host_ld = 1'b1;
          half_d  = 1'b0;
          state_d = ST_RD;
        end else if ((dir_q == DIR_EMPTY) && host_rd) begin
          if (ptr_q == item_count) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            half_d  = 1'b0;
            state_d = ST_FA;
          end
        end
      end
      ST_RD: begin
        state_d = ST_WR;
      end
      ST_WR: begin
        ram_we = 1'b1;
        if (!mode8_q && !half_q) begin
          half_d  = 1'b1;
          state_d = ST_RD;
        end else begin
          half_d = 1'b0;
          ptr_d  = ptr_inc;
          if (!last_item) begin
            state_d = ST_WAIT;
          end else if (mode8_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            clr_d   = ADDR_W'(PACKED);
            state_d = ST_CLR;
          end
        end
      end
      ST_CLR: begin
        ram_we    = 1'b1;
        clear_sel = 1'b1;
        clr_d     = clr_q + 1'b1;
        if (clr_q == ADDR_W'(SECTOR_BYTES - 1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_FA: begin
        state_d = ST_FB;
      end
      ST_FB: begin
        if (mode8_q) begin
          fetch_ld = 1'b1;
          ptr_d    = ptr_inc;
          state_d  = ST_WAIT;
        end else begin
          tmp_ld  = 1'b1;
          half_d  = 1'b1;
          state_d = ST_FC;
        end
      end
      ST_FC: begin
        fetch_ld = 1'b1;
        ptr_d    = ptr_inc;
        half_d   = 1'b0;
        state_d  = ST_WAIT;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
      clr_q   <= '0;
      mode8_q <= 1'b0;
      dir_q   <= DIR_FILL;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      half_q  <= half_d;
      done_q  <= done_d;
      clr_q   <= clr_d;
      if (cfg_en) begin
        mode8_q <= start_mode8;
        dir_q   <= start_dir;
      end
    end
  end

  always_comb begin
    if (state_q == ST_CLR) begin
      ram_addr = clr_q;
    end else if (mode8_q) begin
      ram_addr = ptr_q[ADDR_W-1:0];
    end else begin
      ram_addr = word_base + ADDR_W'(hi_sel);
    end
  end

  assign xfer_ready = (state_q == ST_WAIT);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign mode8      = mode8_q;
  assign dir_empty  = dir_q;
  assign ptr        = ptr_q;
  assign odd        = ptr_q[0];
  assign half       = half_q;

endmodule

// File: rtl/sector_packer.sv
`timescale 1ns/1ps
module sector_packer
  import sector_pack_pkg::*;
#(
  parameter int SECTOR_BYTES = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_mode8,
  input  logic              start_dir,
  input  logic              host_we,
  input  logic [11:0]       host_wdata,
  input  logic              host_rd,
  input  logic [11:0]       acc_in,
  output logic [11:0]       data_out,
  output logic              xfer_ready,
  output logic              done
);

  localparam int ADDR_W = $clog2(SECTOR_BYTES);
  localparam int PTR_W  = ADDR_W + 1;

  // reset: asserted at once, released through a short synchronizer
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_s = rst_sync_q[SYNC_STAGES-1];

  logic              busy, mode8, dir_empty, odd, half;
  logic              ram_we, clear_sel, host_ld, fetch_ld, tmp_ld;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] ram_addr;
  logic [BYTE_W-1:0] ram_rdata, ram_wdata, lane_byte, tmp_q;
  logic [WORD_W-1:0] dbr_q, lane_word;

  pack_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_s),
    .start       (start),
    .start_mode8 (start_mode8),
    .start_dir   (start_dir),
    .host_we     (host_we),
    .host_rd     (host_rd),
    .xfer_ready  (xfer_ready),
    .done        (done),
    .busy        (busy),
    .mode8       (mode8),
    .dir_empty   (dir_empty),
    .ptr         (ptr),
    .odd         (odd),
    .half        (half),
    .ram_we      (ram_we),
    .clear_sel   (clear_sel),
    .host_ld     (host_ld),
    .fetch_ld    (fetch_ld),
    .tmp_ld      (tmp_ld),
    .ram_addr    (ram_addr)
  );

  pack_lane lane_i (
    .mode8    (mode8),
    .odd      (odd),
    .half     (half),
    .word     (dbr_q),
    .old_byte (ram_rdata),
    .hi_byte  (tmp_q),
    .lo_byte  (ram_rdata),
    .wr_byte  (lane_byte),
    .rd_word  (lane_word)
  );

  assign ram_wdata = clear_sel ? '0 : lane_byte;

  sector_ram #(.DEPTH(SECTOR_BYTES), .WIDTH(BYTE_W)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  // host data register and first-byte holding register
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dbr_q <= '0;
      tmp_q <= '0;
    end else begin
      if (host_ld) begin
        dbr_q <= host_wdata;
      end else if (fetch_ld) begin
        dbr_q <= lane_word;
      end
      if (tmp_ld) begin
        tmp_q <= ram_rdata;
      end
    end
  end

  always_comb begin
    if (mode8) begin
      data_out = acc_in | {{(WORD_W-BYTE_W){1'b0}}, dbr_q[BYTE_W-1:0]};
    end else begin
      data_out = dbr_q;
    end
  end

  logic unused_busy;
  assign unused_busy = ^{busy, dir_empty, ptr};

endmodule

// File: rtl/sector_packer_chk.sv
`timescale 1ns/1ps
module sector_packer_chk #(
  parameter int SECTOR_BYTES = 128
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic                          start_dir,
  input logic                          host_we,
  input logic                          xfer_ready,
  input logic                          done,
  input logic                          busy,
  input logic                          mode8,
  input logic                          dir_empty,
  input logic [$clog2(SECTOR_BYTES):0] ptr
);

  localparam int PTR_W = $clog2(SECTOR_BYTES) + 1;

  a_r1_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xfer_ready);

  a_r2_fill_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !start_dir) |=> (xfer_ready && !done));

  a_r10_empty_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && start_dir) |=> (!xfer_ready && busy));

  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ready && host_we && !dir_empty) |=> !xfer_ready);

  a_r9_ready_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_ready && done));

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mode8) && $stable(dir_empty)));

  a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mode8 ? (ptr <= PTR_W'(SECTOR_BYTES)) : (ptr <= PTR_W'(SECTOR_BYTES / 2)));

endmodule

bind sector_packer sector_packer_chk #(.SECTOR_BYTES(SECTOR_BYTES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_s),
  .start      (start),
  .start_dir  (start_dir),
  .host_we    (host_we),
  .xfer_ready (xfer_ready),
  .done       (done),
  .busy       (busy),
  .mode8      (mode8),
  .dir_empty  (dir_empty),
  .ptr        (ptr)
);

// File: tb/sector_packer_tb_top.sv
`timescale 1ns/1ps
module sector_packer_tb_top;

  localparam int BYTES  = 128;
  localparam int WORDS  = BYTES / 2;
  localparam int PACKED = (WORDS * 3) / 2;
  localparam int TAIL   = BYTES - PACKED;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, start_mode8, start_dir, host_we, host_rd;
  logic [11:0] host_wdata, acc_in, data_out;
  logic        xfer_ready, done;

  always #2.5 clk = ~clk;

  sector_packer #(.SECTOR_BYTES(BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode8(start_mode8),
    .start_dir(start_dir), .host_we(host_we), .host_wdata(host_wdata),
    .host_rd(host_rd), .acc_in(acc_in), .data_out(data_out),
    .xfer_ready(xfer_ready), .done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit chk_on = 0;
  string ev_tag = "R1";
  string dat_tag = "R8";

  // behavioural reference model
  logic [7:0]  m_mem [BYTES];
  bit          m_busy, m_ready, m_done, m_mode8, m_dir;
  int          m_ptr, cnt, pend;
  logic [11:0] m_exp;

  function automatic logic [11:0] stream_word(int n);
    logic [11:0] v;
    for (int b = 0; b < 12; b++) begin
      int pos = 12 * n + b;
      v[11 - b] = m_mem[pos / 8][7 - (pos % 8)];
    end
    return v;
  endfunction

  task automatic stream_put(int n, logic [11:0] w);
    int nbits = (n % 2 == 0) ? 16 : 12;
    for (int b = 0; b < nbits; b++) begin
      int pos = 12 * n + b;
      m_mem[pos / 8][7 - (pos % 8)] = (b < 12) ? w[11 - b] : 1'b0;
    end
  endtask

  function automatic int m_count();
    return m_mode8 ? BYTES : WORDS;
  endfunction

  task automatic apply_pend();
    if (pend == 1) m_ready = 1;
    else begin m_done = 1; m_busy = 0; end
    pend = 0;
  endtask

  task automatic sched(int lat, int what, string tag);
    ev_tag = tag;
    pend = what;
    cnt = lat - 1;
    if (cnt == 0) apply_pend();
  endtask

  task automatic fetch_next();
    m_exp = m_mode8 ? {4'h0, m_mem[m_ptr]} : stream_word(m_ptr);
    m_ptr++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_done = 0; m_mode8 = 0; m_dir = 0;
      m_ptr = 0; cnt = 0; pend = 0; m_exp = '0;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) apply_pend();
    end else if (!m_busy && start) begin
      m_busy = 1; m_done = 0; m_ready = 0; m_mode8 = start_mode8;
      m_dir = start_dir; m_ptr = 0;
      if (!start_dir) sched(1, 1, "R2");
      else begin fetch_next(); sched(m_mode8 ? 3 : 4, 1, "R10"); end
    end else if (m_ready && !m_dir && host_we) begin
      m_ready = 0;
      if (m_mode8) m_mem[m_ptr] = host_wdata[7:0];
      else stream_put(m_ptr, host_wdata);
      m_ptr++;
      if (m_ptr == m_count()) begin
        if (!m_mode8) for (int i = PACKED; i < BYTES; i++) m_mem[i] = 8'h00;
        sched(m_mode8 ? 3 : 5 + TAIL, 2, "R9");
      end else sched(m_mode8 ? 3 : 5, 1, "R9");
    end else if (m_ready && m_dir && host_rd) begin
      m_ready = 0;
      if (m_ptr == m_count()) sched(1, 2, "R10");
      else begin fetch_next(); sched(m_mode8 ? 3 : 4, 1, "R10"); end
    end
  end

  task automatic chk(string tag, string what, logic [11:0] act, logic [11:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // clock-by-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      chk(ev_tag, "xfer_ready", {11'h0, xfer_ready}, {11'h0, m_ready});
      chk(ev_tag, "done", {11'h0, done}, {11'h0, m_done});
      if (m_ready && m_dir)
        chk(dat_tag, "data_out", data_out, m_mode8 ? (acc_in | m_exp) : m_exp);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      miscompares++;
      $display("FAIL R9 watchdog cycles=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_start(bit mode8, bit dir);
    start_mode8 = mode8; start_dir = dir; start = 1;
    step();
    start = 0; start_mode8 = ~mode8; start_dir = ~dir;
  endtask

  task automatic wait_ready_or_done();
    while (!m_ready && !m_done) step();
  endtask

  task automatic wait_done();
    while (!m_done) step();
  endtask

  // fill one item; optional repeat strobe and ignored start/read (R11)
  task automatic fill_item(logic [11:0] w, bit glitch, bit stray);
    wait_ready_or_done();
    if (stray) begin
      ev_tag = "R11";
      start = 1; start_dir = 1; start_mode8 = ~m_mode8; host_rd = 1;
      step();
      start = 0; host_rd = 0;
    end
    host_we = 1; host_wdata = w;
    step();
    if (glitch) begin
      host_wdata = ~w;
      step();
    end
    host_we = 0;
  endtask

  task automatic empty_all(bit mode8, bit inject_we);
    int k = 0;
    do_start(mode8, 1);
    forever begin
      wait_ready_or_done();
      if (m_done) break;
      if (!mode8) dat_tag = "R6";
      else if (k >= PACKED && dat_tag != "R8") dat_tag = "R7";
      else if (dat_tag != "R8") dat_tag = (k % 3 == 1) ? "R4" : "R5";
      acc_in = 12'(k * 12'h2B1) & 12'hF0F;
      step();
      host_rd = 1;
      if (inject_we) begin host_we = 1; host_wdata = 12'hFFF; end
      step();
      host_rd = 0;
      if (inject_we) step();
      host_we = 0;
      k++;
    end
    step();
  endtask

  initial begin
    rst_n = 0; start = 0; start_mode8 = 0; start_dir = 0;
    host_we = 0; host_rd = 0; host_wdata = '0; acc_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "xfer_ready in reset", {11'h0, xfer_ready}, 12'h0);
    chk("R1", "done in reset", {11'h0, done}, 12'h0);
    chk("R1", "data_out in reset", data_out, 12'h0);
    @(posedge clk); #1;
    rst_n = 1;
    chk_on = 1;
    repeat (4) step();

    // byte-mode fill with a non-zero pattern over the whole buffer (R3, R11)
    do_start(1, 0);
    for (int i = 0; i < BYTES; i++)
      fill_item(12'h700 | 12'((i * 37 + 5) & 8'hFF), (i % 16) == 3, i == 10);
    wait_done();
    step();

    // byte-mode empty with accumulator merge (R3, R8)
    dat_tag = "R8";
    empty_all(1, 0);

    // word-mode fill (R4, R5, R7)
    do_start(0, 0);
    for (int i = 0; i < WORDS; i++)
      fill_item(12'((i * 12'h59D + 12'h123) & 12'hFFF), (i % 9) == 4, i == 33);
    wait_done();
    step();

    // word-mode empty with stray write strobes (R6, R11)
    empty_all(0, 1);

    // byte view of the packed sector and cleared tail (R4, R5, R7)
    dat_tag = "R4";
    empty_all(1, 0);

    repeat (3) step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule